// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block keeps wall-clock time and a calendar: seconds, minutes, hours, day of month, month, two-digit year counted from 2000, and a weekday. Each quantity is read as a BCD byte through a small byte-wide register port, with the hour shown in either 24-hour form or 12-hour form with a PM flag. Time advances by one second each time a programmable number of clock-enable pulses (nominally a 32768 Hz strobe) has been seen. Counting can be paused and resumed.

Software never writes the running time directly. Field writes land in staging registers, and a coded command then copies one staged field, or the whole date and time, into the counters after a range check. A rejected command leaves the time untouched and raises a one-cycle error pulse. The block also offers a calendar alarm, a periodic tick whose rate can be set to once per second, minute, hour or day, and a signed drift correction. The correction stretches or shortens one second out of every compensation period. All three events are single-cycle pulses meant for an external interrupt collector.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time is 00:00:00, day 1, month 1, year 0, weekday 0. The alarm is 00:00:00 on day 1, month 1, year 0. The control and compensation registers read zero.
- R2: The control register (0x00) keeps five bits: bit 0 enables counting, bit 1 enables the alarm, bit 2 selects 12-hour form, and bits 4:3 give the tick rate. Bits 7:5 read zero.
- R3: Writes to the time registers (0x02 second, 0x03 minute, 0x04 hour, 0x05 day, 0x06 month, 0x07 year, 0x08 weekday) only stage values. Reads return the running time. Command codes 1 to 7, written to the command register 0x01 low nibble, commit the single staged field in that same order. Code 0 does nothing. The command register reads zero.
- R4: Command code 8 commits second, minute, hour, day, month and year together and leaves the weekday unchanged.
- R5: A command code above 8 raises error_evt for one cycle and changes no time field. So does any field the command would commit being out of range: second or minute above 59, hour above 23, day outside 1..31, month outside 1..12, year above 99, weekday above 6.
- R6: While control bit 0 is set, the time advances by one second after every TICKS_PER_SEC cycles with tick_en high. While it is clear, the time holds.
- R7: Rollover carries from seconds to minutes, hours, day, month and year. Months have 30 or 31 days. February has 29 days when the year is a multiple of four and 28 otherwise. Year 99 wraps to 0. The weekday steps modulo 7 at each day change.
- R8: In 12-hour form the hour (0x04) and alarm hour (0x0B) read and write as bit 7 = PM and bits 4:0 = BCD 1..12, where 12 AM is hour 0 and 12 PM is hour 12. In 24-hour form they are BCD 0..23.
- R9: tick_evt pulses once per second when the tick rate is 0. With rate 1 it pulses when seconds wrap to 0, with rate 2 when minutes wrap, and with rate 3 when hours wrap at midnight.
- R10: With control bit 1 set, alarm_evt pulses for one cycle when a second step brings the time to exactly the alarm second, minute, hour, day, month and year. With bit 1 clear it never pulses.
- R11: The compensation value is a signed 16-bit count (0x0F high byte, 0x10 low byte) in units of one clock-enable period. Every COMP_PERIOD-th second lasts TICKS_PER_SEC minus that value, with a minimum of one. All other seconds are nominal.
- R12: Alarm registers (0x09 second to 0x0E year) are written and read in BCD, and an alarm month written as 0 is stored as 1. The compensation bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Clock-enable strobe from the 32768 Hz domain |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| tick_evt | output | 1 | Periodic tick pulse |
| alarm_evt | output | 1 | Alarm match pulse |
| error_evt | output | 1 | Rejected update command pulse |

## Verification
Any corrupt counter is visible on the very next register read, because reads show the running fields directly. A range slip such as second 60 or day 0 only shows up when a carry occurs, so the bench forces the carries right at month, leap-year and century boundaries. A prescaler or compensation fault shifts the cycle on which a second lands, and the bench samples one cycle before and on the expected step edge to catch an off-by-one. Faults in event qualification show as missing or extra pulses, which the bench counts over fixed windows.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int COMP_PERIOD   = 3600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       reg_we,
  input  logic [5:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       tick_evt,
  output logic       alarm_evt,
  output logic       error_evt
);
  localparam int PW = $clog2(TICKS_PER_SEC + 32769);
  localparam int LW = PW + 2;
  localparam int CW = (COMP_PERIOD > 1) ? $clog2(COMP_PERIOD) : 1;

  localparam logic [5:0] A_CTRL = 6'h00, A_CMD = 6'h01, A_SEC = 6'h02, A_MIN = 6'h03,
                         A_HOUR = 6'h04, A_DAY = 6'h05, A_MON = 6'h06, A_YEAR = 6'h07,
                         A_WDAY = 6'h08, A_ASEC = 6'h09, A_AMIN = 6'h0A, A_AHOUR = 6'h0B,
                         A_ADAY = 6'h0C, A_AMON = 6'h0D, A_AYEAR = 6'h0E,
                         A_COMPH = 6'h0F, A_COMPL = 6'h10;

  function automatic logic [7:0] bcd2bin(input logic [7:0] v);
    return ({4'b0, v[7:4]} * 8'd10) + {4'b0, v[3:0]};
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [7:0] v);
    logic [7:0] t, r;
    t = v / 8'd10;
    r = v - t * 8'd10;
    return {t[3:0], r[3:0]};
  endfunction

  function automatic logic [7:0] hr_in(input logic [7:0] v, input logic m12);
    logic [7:0] h;
    h = bcd2bin({2'b00, v[5:0]});
    if (!m12) return h;
    if (h > 8'd12 || h == 8'd0) h = 8'd12;
    if (h == 8'd12) h = 8'd0;
    return v[7] ? h + 8'd12 : h;
  endfunction

  function automatic logic [7:0] hr_out(input logic [7:0] h, input logic m12);
    logic [7:0] h12, b;
    if (!m12) return bin2bcd(h);
    h12 = (h >= 8'd12) ? h - 8'd12 : h;
    if (h12 == 8'd0) h12 = 8'd12;
    b = bin2bcd(h12);
    return {(h >= 8'd12), 2'b00, b[4:0]};
  endfunction

  function automatic logic [4:0] days_in(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd2:                      return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  logic [4:0]    ctrl_q;
  logic [15:0]   comp_q;
  logic [PW-1:0] presc_q;
  logic [CW-1:0] cmpc_q;

  logic [5:0] sec_q, min_q;
  logic [4:0] hr_q, day_q;
  logic [3:0] mon_q;
  logic [6:0] yr_q;
  logic [2:0] wd_q;

  logic [7:0] st_sec, st_min, st_hr, st_day, st_mon, st_yr, st_wd;
  logic [7:0] al_sec, al_min, al_hr, al_day, al_mon, al_yr;

  // second length, with the periodic drift correction
  logic signed [LW-1:0] adj;
  logic [PW-1:0] sec_len;
  logic last, step;

  assign adj     = LW'(TICKS_PER_SEC) - LW'($signed(comp_q));
  assign sec_len = (cmpc_q == CW'(COMP_PERIOD - 1))
                   ? ((adj < $signed(LW'(1))) ? PW'(1) : adj[PW-1:0])
                   : PW'(TICKS_PER_SEC);
  assign last    = presc_q >= sec_len - PW'(1);
  assign step    = ctrl_q[0] & tick_en & last;

  // calendar carries
  logic sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap;
  logic [5:0] n_sec, n_min;
  logic [4:0] n_hr, n_day;
  logic [3:0] n_mon;
  logic [6:0] n_yr;
  logic [2:0] n_wd;

  assign sec_wrap = sec_q >= 6'd59;
  assign min_wrap = sec_wrap & (min_q >= 6'd59);
  assign hr_wrap  = min_wrap & (hr_q >= 5'd23);
  assign day_wrap = hr_wrap & (day_q >= days_in(mon_q, yr_q));
  assign mon_wrap = day_wrap & (mon_q >= 4'd12);

  assign n_sec = sec_wrap ? 6'd0 : sec_q + 6'd1;
  assign n_min = !sec_wrap ? min_q : (min_wrap ? 6'd0 : min_q + 6'd1);
  assign n_hr  = !min_wrap ? hr_q  : (hr_wrap  ? 5'd0 : hr_q + 5'd1);
  assign n_day = !hr_wrap  ? day_q : (day_wrap ? 5'd1 : day_q + 5'd1);
  assign n_mon = !day_wrap ? mon_q : (mon_wrap ? 4'd1 : mon_q + 4'd1);
  assign n_yr  = !mon_wrap ? yr_q  : ((yr_q >= 7'd99) ? 7'd0 : yr_q + 7'd1);
  assign n_wd  = !hr_wrap  ? wd_q  : ((wd_q >= 3'd6) ? 3'd0 : wd_q + 3'd1);

  // update command decode
  logic       cmd_wr, bad;
  logic [3:0] code;
  logic ok_sec, ok_min, ok_hr, ok_day, ok_mon, ok_yr, ok_wd;
  logic [7:1] commit;

  assign cmd_wr = reg_we && reg_addr == A_CMD;
  assign code   = reg_wdata[3:0];
  assign ok_sec = st_sec <= 8'd59;
  assign ok_min = st_min <= 8'd59;
  assign ok_hr  = st_hr  <= 8'd23;
  assign ok_day = st_day >= 8'd1 && st_day <= 8'd31;
  assign ok_mon = st_mon >= 8'd1 && st_mon <= 8'd12;
  assign ok_yr  = st_yr  <= 8'd99;
  assign ok_wd  = st_wd  <= 8'd6;

  always_comb begin
    bad = 1'b0;
    if (cmd_wr)
      case (code)
        4'd0: bad = 1'b0;
        4'd1: bad = !ok_sec;
        4'd2: bad = !ok_min;
        4'd3: bad = !ok_hr;
        4'd4: bad = !ok_day;
        4'd5: bad = !ok_mon;
        4'd6: bad = !ok_yr;
        4'd7: bad = !ok_wd;
        4'd8: bad = !(ok_sec && ok_min && ok_hr && ok_day && ok_mon && ok_yr);
        default: bad = 1'b1;
      endcase
  end

  for (genvar i = 1; i <= 7; i++) begin : g_commit
    if (i < 7) begin : g_all
      assign commit[i] = cmd_wr && !bad && (code == 4'(i) || code == 4'd8);
    end else begin : g_one
      assign commit[i] = cmd_wr && !bad && code == 4'(i);
    end
  end

  // running time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cmpc_q  <= '0;
      sec_q <= '0; min_q <= '0; hr_q <= '0;
      day_q <= 5'd1; mon_q <= 4'd1; yr_q <= '0; wd_q <= '0;
    end else begin
      if (ctrl_q[0] && tick_en) presc_q <= last ? '0 : presc_q + PW'(1);
      if (step) cmpc_q <= (cmpc_q == CW'(COMP_PERIOD - 1)) ? '0 : cmpc_q + CW'(1);
      if (commit[1]) sec_q <= st_sec[5:0]; else if (step) sec_q <= n_sec;
      if (commit[2]) min_q <= st_min[5:0]; else if (step) min_q <= n_min;
      if (commit[3]) hr_q  <= st_hr[4:0];  else if (step) hr_q  <= n_hr;
      if (commit[4]) day_q <= st_day[4:0]; else if (step) day_q <= n_day;
      if (commit[5]) mon_q <= st_mon[3:0]; else if (step) mon_q <= n_mon;
      if (commit[6]) yr_q  <= st_yr[6:0];  else if (step) yr_q  <= n_yr;
      if (commit[7]) wd_q  <= st_wd[2:0];  else if (step) wd_q  <= n_wd;
    end
  end

  // software-visible registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      comp_q <= '0;
      st_sec <= '0; st_min <= '0; st_hr <= '0;
      st_day <= 8'd1; st_mon <= 8'd1; st_yr <= '0; st_wd <= '0;
      al_sec <= '0; al_min <= '0; al_hr <= '0;
      al_day <= 8'd1; al_mon <= 8'd1; al_yr <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL:  ctrl_q <= reg_wdata[4:0];
        A_SEC:   st_sec <= bcd2bin({1'b0, reg_wdata[6:0]});
        A_MIN:   st_min <= bcd2bin({1'b0, reg_wdata[6:0]});
        A_HOUR:  st_hr  <= hr_in(reg_wdata, ctrl_q[2]);
        A_DAY:   st_day <= bcd2bin(reg_wdata);
        A_MON:   st_mon <= bcd2bin(reg_wdata);
        A_YEAR:  st_yr  <= bcd2bin(reg_wdata);
        A_WDAY:  st_wd  <= bcd2bin(reg_wdata);
        A_ASEC:  al_sec <= bcd2bin({1'b0, reg_wdata[6:0]});
        A_AMIN:  al_min <= bcd2bin({1'b0, reg_wdata[6:0]});
        A_AHOUR: al_hr  <= hr_in(reg_wdata, ctrl_q[2]);
        A_ADAY:  al_day <= bcd2bin(reg_wdata);
        A_AMON:  al_mon <= (bcd2bin(reg_wdata) == 8'd0) ? 8'd1 : bcd2bin(reg_wdata);
        A_AYEAR: al_yr  <= bcd2bin(reg_wdata);
        A_COMPH: comp_q[15:8] <= reg_wdata;
        A_COMPL: comp_q[7:0]  <= reg_wdata;
        default: ;
      endcase
    end
  end

  // events
  logic tick_hit, alarm_hit;

  always_comb begin
    case (ctrl_q[4:3])
      2'd0: tick_hit = 1'b1;
      2'd1: tick_hit = sec_wrap;
      2'd2: tick_hit = min_wrap;
      default: tick_hit = hr_wrap;
    endcase
  end

  assign alarm_hit = {2'b0, n_sec} == al_sec && {2'b0, n_min} == al_min &&
                     {3'b0, n_hr}  == al_hr  && {3'b0, n_day} == al_day &&
                     {4'b0, n_mon} == al_mon && {1'b0, n_yr}  == al_yr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_evt  <= 1'b0;
      alarm_evt <= 1'b0;
      error_evt <= 1'b0;
    end else begin
      tick_evt  <= step & tick_hit;
      alarm_evt <= step & ctrl_q[1] & alarm_hit;
      error_evt <= bad;
    end
  end

  // read port
  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {3'b0, ctrl_q};
      A_SEC:   reg_rdata = bin2bcd({2'b0, sec_q});
      A_MIN:   reg_rdata = bin2bcd({2'b0, min_q});
      A_HOUR:  reg_rdata = hr_out({3'b0, hr_q}, ctrl_q[2]);
      A_DAY:   reg_rdata = bin2bcd({3'b0, day_q});
      A_MON:   reg_rdata = bin2bcd({4'b0, mon_q});
      A_YEAR:  reg_rdata = bin2bcd({1'b0, yr_q});
      A_WDAY:  reg_rdata = bin2bcd({5'b0, wd_q});
      A_ASEC:  reg_rdata = bin2bcd(al_sec);
      A_AMIN:  reg_rdata = bin2bcd(al_min);
      A_AHOUR: reg_rdata = hr_out(al_hr, ctrl_q[2]);
      A_ADAY:  reg_rdata = bin2bcd(al_day);
      A_AMON:  reg_rdata = bin2bcd(al_mon);
      A_AYEAR: reg_rdata = bin2bcd(al_yr);
      A_COMPH: reg_rdata = comp_q[15:8];
      A_COMPL: reg_rdata = comp_q[7:0];
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_en,
  input logic       alm_en,
  input logic       reg_we,
  input logic [5:0] reg_addr,
  input logic       tick_evt,
  input logic       alarm_evt,
  input logic       error_evt,
  input logic [5:0] sec,
  input logic [5:0] min,
  input logic [4:0] hr,
  input logic [4:0] day,
  input logic [3:0] mon
);
  assert_time_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sec <= 6'd59 && min <= 6'd59 && hr <= 5'd23);

  assert_date_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    day >= 5'd1 && day <= 5'd31 && mon >= 4'd1 && mon <= 4'd12);

  assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !(reg_we && reg_addr == 6'h01)) |=>
      ($stable(sec) && $stable(min) && $stable(hr) && $stable(day) && $stable(mon)));

  assert_tick_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |-> $past(run_en));

  assert_alarm_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |-> ($past(alm_en) && $past(run_en)));

  assert_error_from_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    error_evt |-> $past(reg_we && reg_addr == 6'h01));
endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(ctrl_q[0]), .alm_en(ctrl_q[1]),
  .reg_we(reg_we), .reg_addr(reg_addr), .tick_evt(tick_evt),
  .alarm_evt(alarm_evt), .error_evt(error_evt),
  .sec(sec_q), .min(min_q), .hr(hr_q), .day(day_q), .mon(mon_q)
);

// File: tb/sim_bcd_rtc.sv
`timescale 1ns/1ps
module sim_bcd_rtc;
  localparam int TPS = 4;
  localparam int CP  = 5;

  localparam logic [7:0] CTRL = 8'h00, CMD = 8'h01, SEC = 8'h02, MIN = 8'h03, HOUR = 8'h04,
                         DAY = 8'h05, MON = 8'h06, YEAR = 8'h07, WDAY = 8'h08, ASEC = 8'h09,
                         AHOUR = 8'h0B, ADAY = 8'h0C, AMON = 8'h0D, AYEAR = 8'h0E,
                         COMPH = 8'h0F, COMPL = 8'h10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick_evt, alarm_evt, error_evt;

  int checks = 0;
  int errors = 0;
  logic last_err;

  always #5 clk = ~clk;

  bcd_rtc #(.TICKS_PER_SEC(TPS), .COMP_PERIOD(CP)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_evt(tick_evt), .alarm_evt(alarm_evt), .error_evt(error_evt)
  );

  // kind(1 write, 2 read-compare), address, data or expected, requirement number
  localparam int NV = 56;
  localparam logic [31:0] VEC [NV] = '{
    {8'd2, CTRL, 8'h00, 8'd1}, {8'd2, SEC, 8'h00, 8'd1}, {8'd2, HOUR, 8'h00, 8'd1},   // R1
    {8'd2, DAY, 8'h01, 8'd1},  {8'd2, MON, 8'h01, 8'd1}, {8'd2, YEAR, 8'h00, 8'd1},
    {8'd2, ASEC, 8'h00, 8'd1}, {8'd2, ADAY, 8'h01, 8'd1}, {8'd2, AMON, 8'h01, 8'd1},
    {8'd2, AYEAR, 8'h00, 8'd1}, {8'd2, COMPH, 8'h00, 8'd1}, {8'd2, COMPL, 8'h00, 8'd1},
    {8'd1, CTRL, 8'hFF, 8'd2}, {8'd2, CTRL, 8'h1F, 8'd2}, {8'd1, CTRL, 8'h00, 8'd2},  // R2
    {8'd1, SEC, 8'h45, 8'd3},  {8'd2, SEC, 8'h00, 8'd3}, {8'd1, CMD, 8'h00, 8'd3},    // R3
    {8'd2, SEC, 8'h00, 8'd3},  {8'd1, CMD, 8'h01, 8'd3}, {8'd2, SEC, 8'h45, 8'd3},
    {8'd2, CMD, 8'h00, 8'd3},  {8'd1, WDAY, 8'h05, 8'd3}, {8'd2, WDAY, 8'h00, 8'd3},
    {8'd1, CMD, 8'h07, 8'd3},  {8'd2, WDAY, 8'h05, 8'd3},
    {8'd1, SEC, 8'h10, 8'd4},  {8'd1, MIN, 8'h30, 8'd4}, {8'd1, HOUR, 8'h17, 8'd4},   // R4
    {8'd1, DAY, 8'h25, 8'd4},  {8'd1, MON, 8'h12, 8'd4}, {8'd1, YEAR, 8'h99, 8'd4},
    {8'd2, MIN, 8'h00, 8'd4},  {8'd1, CMD, 8'h08, 8'd4}, {8'd2, SEC, 8'h10, 8'd4},
    {8'd2, MIN, 8'h30, 8'd4},  {8'd2, HOUR, 8'h17, 8'd4}, {8'd2, DAY, 8'h25, 8'd4},
    {8'd2, MON, 8'h12, 8'd4},  {8'd2, YEAR, 8'h99, 8'd4}, {8'd2, WDAY, 8'h05, 8'd4},
    {8'd1, CTRL, 8'h04, 8'd8}, {8'd2, HOUR, 8'h85, 8'd8}, {8'd1, AHOUR, 8'h92, 8'd8}, // R8
    {8'd2, AHOUR, 8'h92, 8'd8}, {8'd1, CTRL, 8'h00, 8'd8}, {8'd2, AHOUR, 8'h12, 8'd8},
    {8'd2, HOUR, 8'h17, 8'd8},
    {8'd1, ASEC, 8'h33, 8'd12}, {8'd2, ASEC, 8'h33, 8'd12}, {8'd1, AMON, 8'h00, 8'd12}, // R12
    {8'd2, AMON, 8'h01, 8'd12}, {8'd1, COMPL, 8'hAB, 8'd12}, {8'd1, COMPH, 8'hCD, 8'd12},
    {8'd2, COMPL, 8'hAB, 8'd12}, {8'd2, COMPH, 8'hCD, 8'd12}
  };

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[5:0]; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    last_err = error_evt;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] v);
    reg_addr = a[5:0];
    #1 v = reg_rdata;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    peek(a, v);
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_all(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                         input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    wr(SEC, s); wr(MIN, m); wr(HOUR, h); wr(DAY, d); wr(MON, mo); wr(YEAR, y);
    wr(CMD, 8'h08);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cnt;
    do_reset();
    check(1, "tick_evt after reset", {7'b0, tick_evt}, 8'h00);   // R1
    check(1, "alarm_evt after reset", {7'b0, alarm_evt}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][31:24] == 8'd1) wr(VEC[i][23:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][23:16], v);
        check(int'(VEC[i][7:0]), $sformatf("table entry %0d", i), v, VEC[i][15:8]);
      end
    end

    // R5: rejected commands
    do_reset();
    wr(HOUR, 8'h24); wr(CMD, 8'h03);
    check(5, "error on hour 24", {7'b0, last_err}, 8'h01);
    rd(HOUR, v); check(5, "hour unchanged", v, 8'h00);
    wr(CMD, 8'h09);
    check(5, "error on code 9", {7'b0, last_err}, 8'h01);
    wr(CMD, 8'h0F);
    check(5, "error on code 15", {7'b0, last_err}, 8'h01);
    wr(CMD, 8'h00);
    check(5, "no error on code 0", {7'b0, last_err}, 8'h00);
    wr(MON, 8'h13); wr(CMD, 8'h05);
    check(5, "error on month 13", {7'b0, last_err}, 8'h01);
    wr(MON, 8'h00); wr(CMD, 8'h05);
    check(5, "error on month 0", {7'b0, last_err}, 8'h01);
    rd(MON, v); check(5, "month unchanged", v, 8'h01);
    wr(SEC, 8'h60); wr(CMD, 8'h01);
    check(5, "error on second 60", {7'b0, last_err}, 8'h01);
    wr(SEC, 8'h07); wr(HOUR, 8'h23); wr(MON, 8'h02); wr(DAY, 8'h00); wr(CMD, 8'h08);
    check(5, "error on day 0 in full commit", {7'b0, last_err}, 8'h01);
    rd(SEC, v); check(5, "second unchanged after full reject", v, 8'h00);
    wr(CMD, 8'h03);
    check(5, "valid hour accepted", {7'b0, last_err}, 8'h00);
    rd(HOUR, v); check(5, "hour 23 committed", v, 8'h23);
    wr(CTRL, 8'h04);
    rd(HOUR, v); check(8, "hour 23 in 12h form", v, 8'h91);   // R8
    wr(HOUR, 8'h12); wr(CMD, 8'h03);
    rd(HOUR, v); check(8, "12 AM reads 12 without PM", v, 8'h12);
    wr(CTRL, 8'h00);
    rd(HOUR, v); check(8, "12 AM is hour 0", v, 8'h00);

    // R6: second pacing and hold
    do_reset();
    wr(CTRL, 8'h01);
    run(3); peek(SEC, v); check(6, "no step before period", v, 8'h00);
    run(1); peek(SEC, v); check(6, "first step", v, 8'h01);
    run(4); peek(SEC, v); check(6, "second step", v, 8'h02);
    wr(CTRL, 8'h00);
    run(20); peek(SEC, v); check(6, "held while disabled", v, 8'h02);

    // R7 and R9: midnight and month end, non-leap, tick rate 3
    do_reset();
    set_all(8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03);
    wr(WDAY, 8'h06); wr(CMD, 8'h07);
    wr(CTRL, 8'h19);
    run(4); check(9, "no daily tick at :59", {7'b0, tick_evt}, 8'h00);
    peek(SEC, v); check(7, "second 59", v, 8'h59);
    run(4); check(9, "daily tick at midnight", {7'b0, tick_evt}, 8'h01);
    wr(CTRL, 8'h00);
    rd(HOUR, v); check(7, "hour wraps", v, 8'h00);
    rd(DAY, v);  check(7, "Feb 28 non-leap wraps to day 1", v, 8'h01);
    rd(MON, v);  check(7, "month advances to 3", v, 8'h03);
    rd(WDAY, v); check(7, "weekday 6 wraps to 0", v, 8'h00);

    // R7: leap year
    do_reset();
    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h04);
    wr(CTRL, 8'h01);
    run(4); wr(CTRL, 8'h00);
    rd(DAY, v); check(7, "leap Feb 29", v, 8'h29);
    rd(MON, v); check(7, "still February", v, 8'h02);

    // R7: 30-day month and century wrap
    do_reset();
    set_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h10);
    wr(CTRL, 8'h01); run(4); wr(CTRL, 8'h00);
    rd(MON, v); check(7, "April 30 rolls to May", v, 8'h05);
    do_reset();
    set_all(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
    wr(CTRL, 8'h01); run(4); wr(CTRL, 8'h00);
    rd(YEAR, v); check(7, "year 99 wraps to 0", v, 8'h00);
    rd(MON, v);  check(7, "December wraps to January", v, 8'h01);
    rd(DAY, v);  check(7, "day 31 wraps to 1", v, 8'h01);

    // R9: rates 0, 1, 2
    do_reset();
    wr(CTRL, 8'h01);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin run(1); if (tick_evt) cnt++; end
    check(9, "rate 0 ticks in 3 seconds", 8'(cnt), 8'd3);
    do_reset();
    wr(SEC, 8'h57); wr(CMD, 8'h01); wr(CTRL, 8'h09);
    cnt = 0;
    for (int i = 0; i < 16; i++) begin run(1); if (tick_evt) cnt++; end
    check(9, "rate 1 ticks across one minute wrap", 8'(cnt), 8'd1);
    do_reset();
    wr(SEC, 8'h58); wr(MIN, 8'h59); wr(CMD, 8'h08); wr(CTRL, 8'h11);
    cnt = 0;
    for (int i = 0; i < 16; i++) begin run(1); if (tick_evt) cnt++; end
    check(9, "rate 2 ticks across one hour wrap", 8'(cnt), 8'd1);

    // R10: alarm
    do_reset();
    wr(ASEC, 8'h02); wr(CTRL, 8'h03);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin run(1); if (alarm_evt) cnt++; end
    check(10, "alarm pulses once at match", 8'(cnt), 8'd1);
    do_reset();
    wr(ASEC, 8'h02); wr(CTRL, 8'h01);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin run(1); if (alarm_evt) cnt++; end
    check(10, "no alarm when disabled", 8'(cnt), 8'd0);
    do_reset();
    wr(ASEC, 8'h02); wr(ADAY, 8'h02); wr(CTRL, 8'h03);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin run(1); if (alarm_evt) cnt++; end
    check(10, "no alarm on date mismatch", 8'(cnt), 8'd0);

    // R11: compensation on every fifth second
    do_reset();
    wr(COMPL, 8'h02); wr(CTRL, 8'h01);
    run(17); peek(SEC, v); check(11, "shortened second not yet done", v, 8'h04);
    run(1);  peek(SEC, v); check(11, "shortened second ends", v, 8'h05);
    run(3);  peek(SEC, v); check(11, "nominal second after correction", v, 8'h05);
    run(1);  peek(SEC, v); check(11, "nominal second ends", v, 8'h06);
    do_reset();
    wr(COMPL, 8'hFE); wr(COMPH, 8'hFF); wr(CTRL, 8'h01);
    run(21); peek(SEC, v); check(11, "lengthened second not yet done", v, 8'h04);
    run(1);  peek(SEC, v); check(11, "lengthened second ends", v, 8'h05);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule